// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the status and write-protection state of a serial NOR flash device and serves it over an SPI slave port in mode 0 (data sampled on the rising clock edge, driven after the falling edge). The SPI pins are oversampled on the system clock through a synchroniser. The first byte of each chip-select window is the instruction. A status-read instruction turns the data-out line on and returns the 8-bit status register for as long as the host keeps clocking. Write-enable, write-disable and status-write instructions change the latch and the protection bits. Program and erase requests are accepted or refused from the latch, the protection bits and a target-in-protected-area flag.

An accepted status write, program or erase raises the busy flag (WIP) for a fixed number of system clocks, counted down by an internal counter that stands in for the real array cycle. The block reports each accepted cycle with a one-clock pulse and a kind code. The memory array and the decoding of addresses are outside the block. Whether the targeted area lies inside the protected range arrives as a single input. A protection bit together with the write-protect pin puts the device into a hardware-locked mode.

Top module: `sfsr_ctrl`

## Requirements
- R1: After reset the status register reads 0x00. Its bit layout is b7 lock bit, b6 and b5 always 0, b4..b2 protect bits, b1 write-enable latch (WEL), b0 busy (WIP). Opcode 0x05 reads it and returns it MSB first.
- R2: spi_miso_oe is 0 while the instruction byte is clocked in and whenever chip select is high. It is 1 for every data-out bit of a status read.
- R3: While chip select stays low after 0x05, the register is sent again for each further 8 clocks. Each byte carries the value current when that byte starts.
- R4: Opcode 0x06 sets WEL and opcode 0x04 clears it, but only when the window holds exactly one byte.
- R5: An instruction is executed only when chip select rises on a byte boundary. A window ending after a partial byte has no effect.
- R6: Opcode 0x01 followed by exactly one data byte, with WEL set, loads data bit 7 into the lock bit and data bits 4..2 into the protect bits. All other data bits are ignored, and a window with any other byte count has no effect.
- R7: An accepted cycle gives one exec_valid pulse with exec_kind 0 for status write, 1 for page program, 2 for sector erase, 3 for block erase and 4 for chip erase. busy (WIP) is then 1 for exactly BUSY_CYCLES clocks.
- R8: WEL is cleared in the same clock in which WIP returns to 0 at the end of a cycle.
- R9: With WEL at 0, status write, page program, sector erase, block erase and chip erase are refused. Nothing starts and the register is unchanged.
- R10: Page program (0x02), sector erase (0x20) and block erase (0xD8) accept any number of bytes after the opcode. They are refused when any protect bit is 1 and tgt_in_prot is 1. A refusal leaves WEL as it was.
- R11: Chip erase (0xC7), with exactly one byte in the window, runs only when all three protect bits are 0.
- R12: When the lock bit is 1 and wp_n is low, a status write is ignored. The lock and protect bits keep their values and WEL is unchanged.
- R13: While WIP is 1, every instruction except status read is ignored. Status read works during a busy cycle.
- R14: An opcode not listed above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_mosi | input | 1 | SPI data from host |
| wp_n | input | 1 | Write-protect pin, active low |
| tgt_in_prot | input | 1 | High when the program or erase target lies in the protected area |
| spi_miso | output | 1 | SPI data to host |
| spi_miso_oe | output | 1 | Output enable for spi_miso; 0 means high impedance |
| busy | output | 1 | Busy flag (WIP), high during a modelled cycle |
| exec_valid | output | 1 | One-clock pulse when a cycle is accepted |
| exec_kind | output | 3 | Kind of the accepted cycle, valid with exec_valid |

## Verification
The bench builds the block with BUSY_CYCLES at 400 and two synchroniser stages. At that length a busy cycle lasts several status bytes, so one chip-select window can poll WIP across its fall, and an instruction sent during the cycle can be shown to be ignored before the cycle ends. It sweeps all eight protect-bit patterns against both target flags and all four program and erase opcodes. For each case it computes acceptance from the rules and checks the pulse, the kind code, the status bytes and the measured busy length.

// File: rtl/sfsr_pkg.sv
// Package: opcodes and cycle-kind codes shared by the status register controller.
package sfsr_pkg;

    localparam logic [7:0] OPC_RD_STAT = 8'h05;
    localparam logic [7:0] OPC_WR_STAT = 8'h01;
    localparam logic [7:0] OPC_WEN     = 8'h06;
    localparam logic [7:0] OPC_WDIS    = 8'h04;
    localparam logic [7:0] OPC_PROG    = 8'h02;
    localparam logic [7:0] OPC_SECT    = 8'h20;
    localparam logic [7:0] OPC_BLK     = 8'hD8;
    localparam logic [7:0] OPC_CHIP    = 8'hC7;

    // Kind code reported with each accepted cycle
    typedef enum logic [2:0] {
        CYC_STWR = 3'd0,
        CYC_PROG = 3'd1,
        CYC_SECT = 3'd2,
        CYC_BLK  = 3'd3,
        CYC_CHIP = 3'd4
    } cyc_kind_e;

endpackage

// File: rtl/sfsr_sync.sv
// Module: sfsr_sync
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no coherency across bits is promised.
module sfsr_sync #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_lvl
);

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] q;
            if (g == 0) begin : g_first
                // First stage captures the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) q <= RST_VAL;
                    else        q <= d_in;
                end
            end else begin : g_next
                // Later stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) q <= RST_VAL;
                    else        q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    assign q_lvl = g_stage[STAGES-1].q;

endmodule

// File: rtl/sfsr_shifter.sv
// Module: sfsr_shifter
// Mode-0 serial engine: shifts bytes in on SCK rising events and, once
// told to, streams a snapshot of a word out on SCK falling events,
// reloading a fresh snapshot at every byte. Assumes the edge strobes
// come from an oversampled, synchronised SCK and are one clock wide.
module sfsr_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_act,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              sdi,
    input  logic              rd_go,
    input  logic [BYTE_W-1:0] snap_src,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              at_boundary,
    output logic              sdo,
    output logic              sdo_en
);

    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  in_cnt;
    logic [BYTE_W-1:0] in_sh;
    logic              rd_armed;
    logic              rd_live;
    logic [CNT_W-1:0]  out_cnt;
    logic [BYTE_W-1:0] out_sh;

    // Input shift: count bits of the current byte and assemble it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt    <= '0;
            in_sh     <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else if (!frame_act) begin
            in_cnt    <= '0;
            in_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (bit_rise) begin
                in_sh <= {in_sh[BYTE_W-2:0], sdi};
                if (in_cnt == LAST_BIT) begin
                    in_cnt    <= '0;
                    byte_done <= 1'b1;
                    byte_val  <= {in_sh[BYTE_W-2:0], sdi};
                end else begin
                    in_cnt <= in_cnt + 1'b1;
                end
            end
        end
    end

    // Output shift: reload a snapshot every byte, shift on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_armed <= 1'b0;
            rd_live  <= 1'b0;
            out_cnt  <= '0;
            out_sh   <= '0;
        end else if (!frame_act) begin
            rd_armed <= 1'b0;
            rd_live  <= 1'b0;
            out_cnt  <= '0;
        end else if (rd_go) begin
            rd_armed <= 1'b1;
            out_cnt  <= LAST_BIT;
        end else if (rd_armed && bit_fall) begin
            rd_live <= 1'b1;
            if (out_cnt == LAST_BIT) begin
                out_sh  <= snap_src;
                out_cnt <= '0;
            end else begin
                out_sh  <= {out_sh[BYTE_W-2:0], 1'b0};
                out_cnt <= out_cnt + 1'b1;
            end
        end
    end

    assign at_boundary = (in_cnt == '0);
    assign sdo         = out_sh[BYTE_W-1];
    assign sdo_en      = rd_live;

endmodule

// File: rtl/sfsr_busy.sv
// Module: sfsr_busy
// Countdown that models an array cycle: start loads CYCLES, busy holds
// while the count is non-zero, done marks the clock it returns to zero.
// Assumes start is never raised while busy.
module sfsr_busy #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt;

    // Load on start, then decrement to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/sfsr_ctrl.sv
// Module: sfsr_ctrl (top)
// Status register and write-protection logic of a serial NOR flash behind
// an SPI mode-0 slave. Decodes status read, status write, latch set/clear,
// program and erase opcodes; executes on a byte-aligned chip-select rise;
// models busy time with a countdown. Assumes SCK is slower than clk by a
// margin that lets SYNC_STAGES plus edge detection settle each half period,
// and that tgt_in_prot is steady around the end of a window.
module sfsr_ctrl
    import sfsr_pkg::*;
#(
    parameter int BUSY_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    input  logic       wp_n,
    input  logic       tgt_in_prot,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    output logic       busy,
    output logic       exec_valid,
    output logic [2:0] exec_kind
);

    localparam int NSYNC  = 5;
    localparam int BYTE_W = 8;
    localparam logic [NSYNC-1:0] SYNC_RST = 5'b01001;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] lvl;
    logic cs_lvl, sck_lvl, mosi_lvl, wp_lvl, tgt_lvl;
    logic cs_prev, sck_prev;
    logic cs_end, sck_rise, sck_fall, frame_act;

    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              at_boundary;
    logic              rd_go;

    logic [BYTE_W-1:0] opc;
    logic [1:0]        nbytes;
    logic              ign;
    logic              stg_lock;
    logic [2:0]        stg_bp;

    logic              sr_srwd;
    logic [2:0]        sr_bp;
    logic              sr_wel;
    logic              wip;
    logic              busy_done;
    logic              hw_lock;
    logic [BYTE_W-1:0] stat_word;

    logic              go;
    cyc_kind_e         go_kind;
    logic              set_wel, clr_wel, wr_stat;
    cyc_kind_e         kind_q;

    assign raw_in = {tgt_in_prot, wp_n, spi_mosi, spi_sck, spi_cs_n};

    sfsr_sync #(
        .WIDTH   (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .q_lvl (lvl)
    );

    assign cs_lvl   = lvl[0];
    assign sck_lvl  = lvl[1];
    assign mosi_lvl = lvl[2];
    assign wp_lvl   = lvl[3];
    assign tgt_lvl  = lvl[4];

    // Previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end

    assign cs_end    = cs_lvl & ~cs_prev;
    assign sck_rise  = sck_lvl & ~sck_prev;
    assign sck_fall  = ~sck_lvl & sck_prev;
    assign frame_act = ~cs_lvl;

    assign hw_lock   = sr_srwd & ~wp_lvl;
    assign stat_word = {sr_srwd, 2'b00, sr_bp, sr_wel, wip};
    assign rd_go     = byte_done && (nbytes == 2'd0) && (byte_val == OPC_RD_STAT);

    sfsr_shifter #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_act   (frame_act),
        .bit_rise    (sck_rise),
        .bit_fall    (sck_fall),
        .sdi         (mosi_lvl),
        .rd_go       (rd_go),
        .snap_src    (stat_word),
        .byte_done   (byte_done),
        .byte_val    (byte_val),
        .at_boundary (at_boundary),
        .sdo         (spi_miso),
        .sdo_en      (spi_miso_oe)
    );

    sfsr_busy #(
        .CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go),
        .busy  (wip),
        .done  (busy_done)
    );

    // Frame decode: capture opcode, first data byte and a byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc      <= '0;
            nbytes   <= '0;
            ign      <= 1'b0;
            stg_lock <= 1'b0;
            stg_bp   <= '0;
        end else if (!frame_act) begin
            opc    <= '0;
            nbytes <= '0;
            ign    <= 1'b0;
        end else if (byte_done) begin
            if (nbytes == 2'd0) begin
                opc <= byte_val;
                ign <= wip && (byte_val != OPC_RD_STAT);
            end
            if (nbytes == 2'd1) begin
                stg_lock <= byte_val[7];
                stg_bp   <= byte_val[4:2];
            end
            if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
        end
    end

    // Execution decision at a byte-aligned end of window
    always_comb begin
        go      = 1'b0;
        go_kind = CYC_STWR;
        set_wel = 1'b0;
        clr_wel = 1'b0;
        wr_stat = 1'b0;
        if (cs_end && at_boundary && !ign && !wip) begin
            case (opc)
                OPC_WEN: begin
                    set_wel = (nbytes == 2'd1);
                end
                OPC_WDIS: begin
                    clr_wel = (nbytes == 2'd1);
                end
                OPC_WR_STAT: begin
                    if ((nbytes == 2'd2) && sr_wel && !hw_lock) begin
                        go      = 1'b1;
                        wr_stat = 1'b1;
                        go_kind = CYC_STWR;
                    end
                end
                OPC_PROG, OPC_SECT, OPC_BLK: begin
                    if ((nbytes != 2'd0) && sr_wel && !((sr_bp != 3'b000) && tgt_lvl)) begin
                        go = 1'b1;
                        if (opc == OPC_PROG)      go_kind = CYC_PROG;
                        else if (opc == OPC_SECT) go_kind = CYC_SECT;
                        else                      go_kind = CYC_BLK;
                    end
                end
                OPC_CHIP: begin
                    if ((nbytes == 2'd1) && sr_wel && (sr_bp == 3'b000)) begin
                        go      = 1'b1;
                        go_kind = CYC_CHIP;
                    end
                end
                default: begin
                    go = 1'b0;
                end
            endcase
        end
    end

    // Status bits and the accepted-cycle report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_wel     <= 1'b0;
            sr_srwd    <= 1'b0;
            sr_bp      <= '0;
            exec_valid <= 1'b0;
            kind_q     <= CYC_STWR;
        end else begin
            exec_valid <= go;
            if (go) kind_q <= go_kind;
            if (busy_done)    sr_wel <= 1'b0;
            else if (set_wel) sr_wel <= 1'b1;
            else if (clr_wel) sr_wel <= 1'b0;
            if (wr_stat) begin
                sr_srwd <= stg_lock;
                sr_bp   <= stg_bp;
            end
        end
    end

    assign busy      = wip;
    assign exec_kind = kind_q;

endmodule

// File: rtl/sfsr_chk.sv
// Module: sfsr_chk
// Property checker for sfsr_ctrl, attached by bind below.
module sfsr_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_miso_oe,
    input logic       busy,
    input logic       exec_valid,
    input logic [2:0] exec_kind,
    input logic       wel,
    input logic       srwd,
    input logic [2:0] bp,
    input logic       wp_lvl
);

    localparam int LIM = SYNC_STAGES + 2;

    int cs_hi_cnt;

    // Consecutive clocks with chip select high, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)             cs_hi_cnt <= 0;
        else if (!spi_cs_n)     cs_hi_cnt <= 0;
        else if (cs_hi_cnt < LIM) cs_hi_cnt <= cs_hi_cnt + 1;
    end

    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt >= LIM) |-> !spi_miso_oe);

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> busy);

    assert_need_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> $past(wel));

    assert_chip_unprot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_kind == 3'd4) |-> (bp == 3'b000));

    assert_end_clears_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_lock_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (srwd && !wp_lvl) |=> $stable({srwd, bp}));

    assert_no_start_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> !$past(busy));

endmodule

bind sfsr_ctrl sfsr_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .busy        (busy),
    .exec_valid  (exec_valid),
    .exec_kind   (exec_kind),
    .wel         (sr_wel),
    .srwd        (sr_srwd),
    .bp          (sr_bp),
    .wp_lvl      (wp_lvl)
);

// File: tb/sim_sfsr_ctrl.sv
module sim_sfsr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int BUSY       = 400;
    localparam int WDOG       = 190000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, tgt = 1'b0;
    logic miso, oe, busy, ev;
    logic [2:0] ek;

    int n_vec = 0, n_bad = 0;
    int ex_cnt = 0, run = 0, last_run = 0;
    logic [2:0] ex_last = '0;
    logic fin = 1'b0;
    logic [7:0] rbuf [16];
    int oe_op, oe_dat, poll_n;
    logic [7:0] poll_first, poll_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfsr_ctrl #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .wp_n(wp_n), .tgt_in_prot(tgt), .spi_miso(miso), .spi_miso_oe(oe),
        .busy(busy), .exec_valid(ev), .exec_kind(ek));

    // Monitor of accepted cycles and busy run length
    always @(posedge clk) begin
        if (ev) begin ex_cnt <= ex_cnt + 1; ex_last <= ek; end
        if (busy) run <= run + 1;
        else begin if (run != 0) last_run <= run; run <= 0; end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] v, input int nb, output logic [7:0] rx, output int oeh);
        rx = '0; oeh = 0;
        for (int i = 0; i < nb; i++) begin
            mosi = v[7-i];
            repeat (HALF) @(negedge clk);
            rx = {rx[6:0], miso};
            if (oe) oeh++;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic fbeg(); @(negedge clk); cs_n = 1'b0; repeat (4) @(negedge clk); endtask
    task automatic fend(); repeat (4) @(negedge clk); cs_n = 1'b1; repeat (10) @(negedge clk); endtask

    // Window with opcode and a number of trailing bytes
    task automatic cmd(input logic [7:0] op, input int extra, input logic [7:0] d);
        logic [7:0] rx; int o;
        fbeg(); xfer(op, 8, rx, o);
        for (int k = 0; k < extra; k++) xfer(d, 8, rx, o);
        fend();
    endtask

    task automatic rdsr(input int n);
        logic [7:0] rx; int o;
        fbeg(); xfer(8'h05, 8, rx, oe_op); oe_dat = 0;
        for (int k = 0; k < n; k++) begin xfer(8'h00, 8, rbuf[k], o); oe_dat += o; end
        fend();
    endtask

    task automatic poll();
        logic [7:0] rx; int o;
        fbeg(); xfer(8'h05, 8, rx, o); poll_n = 0;
        for (int k = 0; k < 12; k++) begin
            xfer(8'h00, 8, rx, o);
            if (k == 0) poll_first = rx;
            poll_n++;
            if (rx[0] == 1'b0) break;
        end
        poll_last = rx;
        fend();
    endtask

    function automatic logic [7:0] sw(input logic l, input logic [2:0] b, input logic w, input logic p);
        return {l, 2'b00, b, w, p};
    endfunction

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!fin) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [4];
        int c0;
        logic acc;
        ops[0] = 8'h02; ops[1] = 8'h20; ops[2] = 8'hD8; ops[3] = 8'hC7;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset value, R2 enable pattern
        chk("R2 oe idle", oe, 0);
        rdsr(4);
        chk("R1 reset status", rbuf[0], 8'h00);
        chk("R2 oe in opcode", oe_op, 0);
        chk("R2 oe in data", oe_dat, 32);
        chk("R3 repeat byte", rbuf[3], 8'h00);

        // R4 latch set/clear
        cmd(8'h06, 0, 8'h00); rdsr(2);
        chk("R4 wel set", rbuf[0], 8'h02);
        chk("R3 repeat with wel", rbuf[1], 8'h02);
        cmd(8'h04, 0, 8'h00); rdsr(1);
        chk("R4 wel clear", rbuf[0], 8'h00);
        cmd(8'h06, 1, 8'h00); rdsr(1);
        chk("R4 two-byte wen ignored", rbuf[0], 8'h00);

        // R5 partial byte
        begin
            logic [7:0] rx; int o;
            fbeg(); xfer(8'h06, 8, rx, o); xfer(8'h00, 1, rx, o); fend();
        end
        rdsr(1);
        chk("R5 non-aligned end", rbuf[0], 8'h00);

        // R9 refusals without latch
        c0 = ex_cnt;
        cmd(8'h01, 1, 8'h1C); cmd(8'h20, 3, 8'h00); cmd(8'hC7, 0, 8'h00);
        chk("R9 no cycle without wel", ex_cnt - c0, 0);
        rdsr(1);
        chk("R9 status unchanged", rbuf[0], 8'h00);

        // R14 unknown opcode
        cmd(8'h06, 0, 8'h00); c0 = ex_cnt;
        cmd(8'hAB, 1, 8'h55); rdsr(1);
        chk("R14 unknown ignored", rbuf[0], 8'h02);
        chk("R14 no cycle", ex_cnt - c0, 0);

        // R6 wrong byte count, then masked data
        cmd(8'h01, 2, 8'hFF); rdsr(1);
        chk("R6 three-byte write ignored", rbuf[0], 8'h02);
        c0 = ex_cnt;
        cmd(8'h01, 1, 8'hFF);
        chk("R7 write pulse", ex_cnt - c0, 1);
        chk("R7 write kind", ex_last, 0);
        poll();
        chk("R3 first poll byte busy", poll_first, 8'h9F);
        chk("R6 stored bits", poll_last, 8'h9C);
        chk("R8 wel cleared at end", poll_last[1], 0);
        chk("R7 busy length", last_run, BUSY);
        cmd(8'h06, 0, 8'h00); cmd(8'h01, 1, 8'h00); poll();
        chk("R6 cleared", poll_last, 8'h00);

        // R13 instructions ignored while busy
        cmd(8'h06, 0, 8'h00); cmd(8'h20, 3, 8'h00);
        cmd(8'h04, 0, 8'h00); c0 = ex_cnt;
        cmd(8'hC7, 0, 8'h00);
        rdsr(1);
        chk("R13 status during busy", rbuf[0], 8'h03);
        chk("R13 no second cycle", ex_cnt - c0, 0);
        poll();
        chk("R13 end state", poll_last, 8'h00);

        // R10 R11 sweep: protect pattern x target flag x opcode
        for (int b = 0; b < 8; b++) begin
            cmd(8'h06, 0, 8'h00);
            cmd(8'h01, 1, {3'b000, b[2:0], 2'b00});
            poll();
            chk("R6 sweep bp load", poll_last, sw(1'b0, b[2:0], 1'b0, 1'b0));
            for (int t = 0; t < 2; t++) begin
                for (int o = 0; o < 4; o++) begin
                    tgt = t[0];
                    cmd(8'h06, 0, 8'h00);
                    c0 = ex_cnt;
                    cmd(ops[o], (o == 3) ? 0 : 3, 8'h00);
                    acc = (o == 3) ? (b == 0) : !((b != 0) && (t == 1));
                    chk((o == 3) ? "R11 chip gate" : "R10 area gate", ex_cnt - c0, acc ? 1 : 0);
                    if (acc) chk("R7 kind code", ex_last, o + 1);
                    rdsr(1);
                    chk("R10 status after request", rbuf[0], sw(1'b0, b[2:0], 1'b1, acc));
                    if (acc) begin
                        poll();
                        chk("R8 wel after cycle", poll_last, sw(1'b0, b[2:0], 1'b0, 1'b0));
                    end
                end
            end
        end
        tgt = 1'b0;
        cmd(8'h04, 0, 8'h00);

        // R12 hardware lock
        cmd(8'h06, 0, 8'h00); cmd(8'h01, 1, 8'h84); poll();
        chk("R12 lock bit set", poll_last, 8'h84);
        wp_n = 1'b0;
        cmd(8'h06, 0, 8'h00); c0 = ex_cnt;
        cmd(8'h01, 1, 8'h00); rdsr(1);
        chk("R12 write ignored", rbuf[0], 8'h86);
        chk("R12 no cycle", ex_cnt - c0, 0);
        wp_n = 1'b1;
        cmd(8'h01, 1, 8'h00); poll();
        chk("R12 unlocked write", poll_last, 8'h00);

        chk("R2 oe idle end", oe, 0);
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule